// File: doc/BRIEF.md
# Priority-Based Reference Clock Selector

This block picks one of five candidate reference inputs for each of two independent clock paths, a main path and an auxiliary path. Each path is either forced, so that software names the input outright, or automatic, so that the block chooses among the inputs an external quality monitor currently flags as good. The choice is based on a 4-bit priority per input and per path. The actual clock multiplexer, the quality monitor and the loop that follows the selection sit outside this block.

Software configures the block through a simple write port. Addresses 0 and 1 hold the main and auxiliary control bytes. Addresses 2 to 4 are priority addresses shared by both paths. A steering input decides which path's priority set a write to those addresses lands in. The selection is worked out combinationally from the current flags and settings and is registered once per clock, so each path's index and valid output change cleanly, one cycle after their cause.

Input numbering is fixed and sets the order used for ties:
- index 1: CMOS input 1
- index 2: differential input 1
- index 3: CMOS input 2
- index 4: differential input 2
- index 5: CMOS input 3

Bit `i` of `qual_i` is the quality flag of index `i+1`.

Top module: `refsel_top`

## Requirements
- R1: After synchronous reset, both paths are in automatic mode, all priorities are 0, and both paths output index 0 with valid low.
- R2: In forced mode (control bit 4 = 1), a select field value of 1 to 5 (control bits 3:0) is output as the index with valid high, whatever the qualification flags are.
- R3: In forced mode, a select field value of 0 or of 6 to 15 gives index 0 with valid low.
- R4: In automatic mode (control bit 4 = 0), only an input whose qualification flag is set and whose priority is non-zero can be chosen.
- R5: Among the eligible inputs in automatic mode, the one with the numerically lowest non-zero priority wins.
- R6: When eligible inputs share the winning priority, the one with the smallest index is chosen.
- R7: When no input is eligible in automatic mode, the path outputs index 0 with valid low.
- R8: A write to a priority address (2: index 1 in bits 3:0 and index 2 in bits 7:4; 3: index 3 in bits 3:0 and index 4 in bits 7:4; 4: index 5 in bits 3:0) updates the main path's priorities when `prio_steer_i` is 0 and the auxiliary path's when it is 1. The other path's priorities are left unchanged.
- R9: A change of flags or of configuration appears on the outputs after exactly one rising clock edge and does not reach them before that edge.
- R10: The two paths have separate control bytes (address 0 for main, address 1 for auxiliary). Each path's mode and selection are independent of the other's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| qual_i | input | 5 | Qualification flag per input, bit i for index i+1 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| prio_steer_i | input | 1 | Target of priority writes: 0 main, 1 auxiliary |
| main_idx_o | output | 4 | Selected index of the main path, 0 when none |
| main_valid_o | output | 1 | Main path has a valid selection |
| aux_idx_o | output | 4 | Selected index of the auxiliary path, 0 when none |
| aux_valid_o | output | 1 | Auxiliary path has a valid selection |

## Verification
Two things can happen in the same cycle: a register write and a change of qualification flags, or a write steered to one path while the other path is re-evaluating its own choice. The bench sweeps all 32 flag patterns against several priority sets, including sets full of ties and sets with disabled inputs. It then writes priorities with the steering bit in each state while the other path sits on a known choice. Each output is compared with a selection computed arithmetically in the bench. The same is done with the main path forced while the auxiliary path stays automatic.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
    parameter int N_IN    = 5;
    parameter int N_PATH  = 2;
    parameter int PRIO_W  = 4;
    parameter int IDX_W   = 4;
    parameter int DATA_W  = 8;
    parameter int ADDR_W  = 3;

    localparam int PRIO_PER_WORD = DATA_W / PRIO_W;
    localparam int CTRL_MODE_BIT = IDX_W;
    localparam int ADDR_CTRL_BASE = 0;
    localparam int ADDR_PRIO_BASE = ADDR_CTRL_BASE + N_PATH;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic                forced;
        idx_t                fsel;
        prio_t [N_IN-1:0]    prio;
    } path_cfg_t;

    typedef struct packed {
        logic valid;
        idx_t idx;
    } pick_t;

    function automatic pick_t forced_pick(input idx_t fsel);
        pick_t r;
        r.valid = (fsel != '0) && (int'(fsel) <= N_IN);
        r.idx   = r.valid ? fsel : '0;
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] prio_addr(input int slot);
        return ADDR_W'(ADDR_PRIO_BASE + slot / PRIO_PER_WORD);
    endfunction

    function automatic logic [ADDR_W-1:0] ctrl_addr(input int path);
        return ADDR_W'(ADDR_CTRL_BASE + path);
    endfunction
endpackage

// File: rtl/refsel_regs.sv
module refsel_regs
    import refsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              steer,
    output path_cfg_t         cfg_o [N_PATH]
);
    for (genvar p = 0; p < N_PATH; p++) begin : g_path
        path_cfg_t q;
        logic      prio_hit;

        assign prio_hit = wr_en && (int'(steer) == p);

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else begin
                if (wr_en && wr_addr == ctrl_addr(p)) begin
                    q.forced <= wr_data[CTRL_MODE_BIT];
                    q.fsel   <= wr_data[IDX_W-1:0];
                end
                if (prio_hit) begin
                    for (int i = 0; i < N_IN; i++) begin
                        if (wr_addr == prio_addr(i)) begin
                            q.prio[i] <= wr_data[(i % PRIO_PER_WORD)*PRIO_W +: PRIO_W];
                        end
                    end
                end
            end
        end

        assign cfg_o[p] = q;
    end
endmodule

// File: rtl/refsel_pick.sv
module refsel_pick
    import refsel_pkg::*;
(
    input  path_cfg_t       cfg,
    input  logic [N_IN-1:0] qual,
    output pick_t           pick
);
    pick_t auto_r;
    prio_t best;

    always_comb begin
        auto_r = '0;
        best   = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (qual[i] && cfg.prio[i] != '0 &&
                (!auto_r.valid || cfg.prio[i] < best)) begin
                auto_r.valid = 1'b1;
                auto_r.idx   = IDX_W'(i + 1);
                best         = cfg.prio[i];
            end
        end
    end

    assign pick = cfg.forced ? forced_pick(cfg.fsel) : auto_r;
endmodule

// File: rtl/refsel_top.sv
module refsel_top
    import refsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_IN-1:0]   qual_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              prio_steer_i,
    output logic [IDX_W-1:0]  main_idx_o,
    output logic              main_valid_o,
    output logic [IDX_W-1:0]  aux_idx_o,
    output logic              aux_valid_o
);
    path_cfg_t cfg [N_PATH];
    pick_t     pick_d [N_PATH];
    pick_t     pick_q [N_PATH];
    path_cfg_t main_cfg;
    path_cfg_t aux_cfg;

    refsel_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .wr_addr (wr_addr_i),
        .wr_data (wr_data_i),
        .steer   (prio_steer_i),
        .cfg_o   (cfg)
    );

    for (genvar p = 0; p < N_PATH; p++) begin : g_sel
        refsel_pick u_pick (
            .cfg  (cfg[p]),
            .qual (qual_i),
            .pick (pick_d[p])
        );

        always_ff @(posedge clk) begin
            if (rst) pick_q[p] <= '0;
            else     pick_q[p] <= pick_d[p];
        end
    end

    assign main_cfg     = cfg[0];
    assign aux_cfg      = cfg[1];
    assign main_idx_o   = pick_q[0].idx;
    assign main_valid_o = pick_q[0].valid;
    assign aux_idx_o    = pick_q[1].idx;
    assign aux_valid_o  = pick_q[1].valid;
endmodule

// File: rtl/refsel_checker.sv
module refsel_checker
    import refsel_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [N_IN-1:0]  qual,
    input path_cfg_t        main_cfg,
    input path_cfg_t        aux_cfg,
    input logic [IDX_W-1:0] main_idx,
    input logic             main_valid,
    input logic [IDX_W-1:0] aux_idx,
    input logic             aux_valid
);
    AST_MAIN_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst)
        !main_valid |-> main_idx == '0); // R7
    AST_AUX_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst)
        !aux_valid |-> aux_idx == '0); // R7
    AST_MAIN_VALID_RANGE: assert property (@(posedge clk) disable iff (rst)
        main_valid |-> (main_idx >= 1 && int'(main_idx) <= N_IN)); // R3
    AST_MAIN_FORCED_ECHO: assert property (@(posedge clk) disable iff (rst)
        ($past(main_cfg.forced) && $past(main_cfg.fsel) >= 1 && int'($past(main_cfg.fsel)) <= N_IN)
        |-> (main_valid && main_idx == $past(main_cfg.fsel))); // R2
    AST_AUX_FORCED_ECHO: assert property (@(posedge clk) disable iff (rst)
        ($past(aux_cfg.forced) && $past(aux_cfg.fsel) >= 1 && int'($past(aux_cfg.fsel)) <= N_IN)
        |-> (aux_valid && aux_idx == $past(aux_cfg.fsel))); // R2
    AST_MAIN_FORCED_RANGE: assert property (@(posedge clk) disable iff (rst)
        ($past(main_cfg.forced) && ($past(main_cfg.fsel) == '0 || int'($past(main_cfg.fsel)) > N_IN))
        |-> !main_valid); // R3
    AST_MAIN_AUTO_QUAL: assert property (@(posedge clk) disable iff (rst)
        (!$past(main_cfg.forced) && main_valid)
        |-> ((($past(qual) >> (main_idx - 1'b1)) & N_IN'(1)) != '0)); // R4
    AST_AUX_AUTO_QUAL: assert property (@(posedge clk) disable iff (rst)
        (!$past(aux_cfg.forced) && aux_valid)
        |-> ((($past(qual) >> (aux_idx - 1'b1)) & N_IN'(1)) != '0)); // R4
endmodule

bind refsel_top refsel_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .qual       (qual_i),
    .main_cfg   (main_cfg),
    .aux_cfg    (aux_cfg),
    .main_idx   (main_idx_o),
    .main_valid (main_valid_o),
    .aux_idx    (aux_idx_o),
    .aux_valid  (aux_valid_o)
);

// File: tb/refsel_top_test.sv
module refsel_top_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] qual = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       steer = 1'b0;
    logic [3:0] main_idx, aux_idx;
    logic       main_valid, aux_valid;

    int checks = 0;
    int failures = 0;
    logic [3:0] pm [5];
    logic [3:0] pa [5];

    always #10 clk = ~clk;

    refsel_top uut (
        .clk(clk), .rst(rst), .qual_i(qual), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .prio_steer_i(steer),
        .main_idx_o(main_idx), .main_valid_o(main_valid),
        .aux_idx_o(aux_idx), .aux_valid_o(aux_valid)
    );

    task automatic chk(input string tag, input logic [3:0] gi, input logic gv,
                       input logic [3:0] ei, input logic ev);
        checks++;
        if (gi !== ei || gv !== ev) begin
            failures++;
            $display("FAIL %s: got idx=%0d valid=%0b, expected idx=%0d valid=%0b",
                     tag, gi, gv, ei, ev);
        end
    endtask

    // reference: scan from index 5 down, replace on lower-or-equal priority
    function automatic logic [4:0] ref_auto(input logic [3:0] p [5], input logic [4:0] q);
        logic [3:0] bi = 0;
        logic [3:0] bp = 0;
        for (int i = 5; i >= 1; i--) begin
            if (q[i-1] && p[i-1] != 0 && (bi == 0 || p[i-1] <= bp)) begin
                bi = 4'(i);
                bp = p[i-1];
            end
        end
        return {bi != 0, bi};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic s);
        wr_en = 1'b1; wr_addr = a; wr_data = d; steer = s;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_prio(input logic s);
        logic [3:0] p [5];
        for (int i = 0; i < 5; i++) p[i] = s ? pa[i] : pm[i];
        wr(3'd2, {p[1], p[0]}, s);
        wr(3'd3, {p[3], p[2]}, s);
        wr(3'd4, {4'h0, p[4]}, s);
    endtask

    task automatic sweep_main(input string tag);
        logic [4:0] e, ea;
        for (int q = 0; q < 32; q++) begin
            qual = 5'(q);
            @(negedge clk);
            e  = ref_auto(pm, qual);
            ea = ref_auto(pa, qual);
            chk(tag, main_idx, main_valid, e[3:0], e[4]);
            chk("R10 aux independent", aux_idx, aux_valid, ea[3:0], ea[4]);
        end
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [4:0] e;
        for (int i = 0; i < 5; i++) begin pm[i] = 0; pa[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset main", main_idx, main_valid, 0, 0);
        chk("R1 reset aux", aux_idx, aux_valid, 0, 0);
        qual = 5'h1F;
        @(negedge clk);
        chk("R1 zero priorities main", main_idx, main_valid, 0, 0);
        chk("R7 none eligible aux", aux_idx, aux_valid, 0, 0);

        // R5 distinct priorities, ascending
        pm = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5};
        load_prio(1'b0);
        sweep_main("R5 ascending");
        pm = '{4'd9, 4'd7, 4'd5, 4'd3, 4'd1};
        load_prio(1'b0);
        sweep_main("R5 descending");
        // R4 disabled inputs and R6 ties
        pm = '{4'd3, 4'd0, 4'd3, 4'd1, 4'd1};
        load_prio(1'b0);
        sweep_main("R6 ties with R4 disabled");
        pm = '{4'd7, 4'd7, 4'd7, 4'd7, 4'd7};
        load_prio(1'b0);
        sweep_main("R6 all tied");

        // R8 steering: aux priorities written, main must stay on all-tied set
        pa = '{4'd4, 4'd4, 4'd2, 4'd0, 4'd1};
        load_prio(1'b1);
        qual = 5'h1F;
        @(negedge clk);
        chk("R8 main unchanged", main_idx, main_valid, 1, 1);
        chk("R8 aux picks index 5", aux_idx, aux_valid, 5, 1);
        sweep_main("R8 both sets");

        // R9 latency: change qual, not visible before edge, visible after
        qual = 5'h1F;
        @(negedge clk);
        qual = 5'h1E;
        #5;
        chk("R9 no early change", main_idx, main_valid, 1, 1);
        @(negedge clk);
        chk("R9 change after one edge", main_idx, main_valid, 2, 1);

        // R2/R3 forced sweep on main while aux stays automatic (R10)
        for (int f = 0; f < 16; f++) begin
            for (int qq = 0; qq < 2; qq++) begin
                qual = qq ? 5'h1F : 5'h00;
                wr(3'd0, {3'b000, 1'b1, 4'(f)}, 1'b0);
                @(negedge clk);
                if (f >= 1 && f <= 5) chk("R2 forced in range", main_idx, main_valid, 4'(f), 1);
                else                  chk("R3 forced out of range", main_idx, main_valid, 0, 0);
                e = ref_auto(pa, qual);
                chk("R10 aux auto while main forced", aux_idx, aux_valid, e[3:0], e[4]);
            end
        end

        // R10 aux forced, main back to automatic
        wr(3'd1, 8'h13, 1'b0);
        wr(3'd0, 8'h00, 1'b0);
        qual = 5'h00;
        @(negedge clk);
        chk("R10 aux forced to 3", aux_idx, aux_valid, 3, 1);
        chk("R7 main auto nothing qualified", main_idx, main_valid, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule